// File: doc/BRIEF.md
# Four-Channel Bus-Hold DMA Controller

This block moves blocks of bytes between peripherals and system memory without the processor touching each byte. Software programs a channel's transfer count, memory start address, peripheral address, burst length and mode, then arms it. When the peripheral raises its request line, the controller asks the processor for the system bus with a hold request. Once hold acknowledge comes back, it strobes byte transfers, one per clock, until the channel's release rule says the bus must go back.

Each channel chooses when the bus is surrendered: after every byte, after a programmed group of bytes, or only when the whole block is done. Four channels share the controller, and a fixed priority picks among them whenever the bus is free. Each byte walks the memory address upward and the count downward. A channel whose count runs out sets its own status bit, and the interrupt line is driven from those bits until software clears them.

Top module: `dmac_quad`

## Requirements
- R1: After reset, no channel is armed, hold_req_o, xfer_stb_o, dack_o, irq_o and irq_status_o are all zero, and raised request lines cause no bus request.
- R2: A configuration write selects a register with cfg_sel: 0 mode, 1 count, 2 memory address, 3 peripheral address, 4 burst length, 5 status clear. Mode word bits [1:0] give the release mode (0 single, 1 burst, 2 bulk, 3 acts as single), bit 2 sets transfer direction toward memory, and bit 3 arms the channel. Writes to an armed channel's registers are ignored.
- R3: hold_req_o rises only after an armed channel's request is seen on an idle bus. No strobe occurs before hold_ack_i is high, and hold_req_o stays high for the whole owned period.
- R4: On a free bus the lowest-numbered armed channel with its request raised wins. A channel that already owns the bus is never pre-empted.
- R5: During a strobe exactly one dack_o bit is high, that of the owning channel, and mem_addr_o, io_addr_o and xfer_to_mem_o show that channel's current memory address, fixed peripheral address and direction.
- R6: Each transferred byte raises the channel's memory address by one and lowers its count by one.
- R7: In single mode the bus is released after one byte.
- R8: In burst mode the bus is released after the burst length in bytes, a burst length of 0 counts as 1, and a burst ends early when the count reaches zero.
- R9: In bulk mode the bus is held until the whole count has been moved, as long as the request stays raised.
- R10: If the owning channel's request is low in a transfer cycle, no byte is strobed and the bus is released in the next cycle.
- R11: When a channel's last byte is strobed, its irq_status_o bit goes high in the next cycle and the channel disarms. irq_o is the OR of the status bits, and no bit is set for intermediate bytes.
- R12: A write with cfg_sel 5 clears each status bit whose cfg_wdata bit is one. A terminal count in the same cycle keeps its bit set.
- R13: Arming a channel whose count is 0 sets its status bit in the next cycle and never raises hold_req_o.
- R14: After the bus is released, a new hold request is raised only once hold_ack_i has been seen low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_chan | input | 2 | Channel addressed by the write |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 16 | Write data |
| drq_i | input | 4 | Per-channel peripheral request |
| dack_o | output | 4 | Per-channel acknowledge, high in the byte's strobe cycle |
| hold_req_o | output | 1 | Bus hold request to the processor |
| hold_ack_i | input | 1 | Bus hold acknowledge from the processor |
| xfer_stb_o | output | 1 | Byte transfer strobe |
| xfer_to_mem_o | output | 1 | 1: peripheral to memory, 0: memory to peripheral |
| mem_addr_o | output | 16 | Memory byte address |
| io_addr_o | output | 16 | Peripheral address |
| irq_o | output | 1 | Level interrupt, any status bit set |
| irq_status_o | output | 4 | Per-channel terminal-count status |

## Verification
The delicate overlap is a software status-clear write landing in the very cycle a channel strobes its final byte, so that clearing and terminal-count setting hit the status register together. The bench provokes it by waiting for the hold request, letting the grant cycle pass, and issuing a clear of two bits exactly in the final transfer cycle. The bit of the finishing channel must survive while the other bit drops. A behavioural reference model tracks every cycle, and queues of episode lengths, channel order and addresses judge release modes and priority.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;

  typedef enum logic [1:0] {
    XM_SINGLE = 2'd0,
    XM_BURST  = 2'd1,
    XM_BULK   = 2'd2,
    XM_RSVD   = 2'd3
  } xmode_e;

  typedef enum logic [1:0] {
    BS_IDLE = 2'd0,
    BS_REQ  = 2'd1,
    BS_XFER = 2'd2
  } bstate_e;

  localparam logic [2:0] RS_MODE   = 3'd0;
  localparam logic [2:0] RS_COUNT  = 3'd1;
  localparam logic [2:0] RS_MADDR  = 3'd2;
  localparam logic [2:0] RS_IOADDR = 3'd3;
  localparam logic [2:0] RS_BURST  = 3'd4;
  localparam logic [2:0] RS_CLEAR  = 3'd5;

  localparam int MB_TOMEM = 2;
  localparam int MB_ARM   = 3;

endpackage

// File: rtl/dmac_chan_regs.sv
`timescale 1ns/1ps
module dmac_chan_regs import dmac_pkg::*; #(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16,
  parameter int DW     = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [2:0]        wr_sel,
  input  logic [DW-1:0]     wr_data,
  input  logic              clr_i,
  input  logic              step_i,
  output xmode_e            mode_o,
  output logic              to_mem_o,
  output logic [CNT_W-1:0]  count_o,
  output logic [ADDR_W-1:0] maddr_o,
  output logic [ADDR_W-1:0] ioaddr_o,
  output logic [CNT_W-1:0]  burst_o,
  output logic              armed_o,
  output logic              done_o
);

  xmode_e             mode_q,   mode_n;
  logic               tomem_q,  tomem_n;
  logic [CNT_W-1:0]   count_q,  count_n;
  logic [ADDR_W-1:0]  maddr_q,  maddr_n;
  logic [ADDR_W-1:0]  ioaddr_q, ioaddr_n;
  logic [CNT_W-1:0]   burst_q,  burst_n;
  logic               armed_q,  armed_n;
  logic               done_q,   done_n;
  logic               wr_ok, set_zero, set_tc, reg_en;

  assign wr_ok  = wr_en && !armed_q;
  assign set_tc = step_i && (count_q == CNT_W'(1));
  assign reg_en = wr_ok || step_i;

  always_comb begin
    mode_n   = mode_q;
    tomem_n  = tomem_q;
    count_n  = count_q;
    maddr_n  = maddr_q;
    ioaddr_n = ioaddr_q;
    burst_n  = burst_q;
    armed_n  = armed_q;
    set_zero = 1'b0;
    if (wr_ok) begin
      case (wr_sel)
        RS_MODE: begin
          mode_n  = xmode_e'(wr_data[1:0]);
          tomem_n = wr_data[MB_TOMEM];
          if (wr_data[MB_ARM]) begin
            if (count_q == '0) set_zero = 1'b1;
            else               armed_n  = 1'b1;
          end
        end
        RS_COUNT:  count_n  = wr_data[CNT_W-1:0];
        RS_MADDR:  maddr_n  = wr_data[ADDR_W-1:0];
        RS_IOADDR: ioaddr_n = wr_data[ADDR_W-1:0];
        RS_BURST:  burst_n  = wr_data[CNT_W-1:0];
        default: ;
      endcase
    end
    if (step_i) begin
      count_n = count_q - CNT_W'(1);
      maddr_n = maddr_q + ADDR_W'(1);
      if (set_tc) armed_n = 1'b0;
    end
    done_n = (done_q && !clr_i) || set_zero || set_tc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= XM_SINGLE;
      tomem_q  <= 1'b0;
      count_q  <= '0;
      maddr_q  <= '0;
      ioaddr_q <= '0;
      burst_q  <= '0;
      armed_q  <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (reg_en) begin
        mode_q   <= mode_n;
        tomem_q  <= tomem_n;
        count_q  <= count_n;
        maddr_q  <= maddr_n;
        ioaddr_q <= ioaddr_n;
        burst_q  <= burst_n;
        armed_q  <= armed_n;
      end
      done_q <= done_n;
    end
  end

  assign mode_o   = mode_q;
  assign to_mem_o = tomem_q;
  assign count_o  = count_q;
  assign maddr_o  = maddr_q;
  assign ioaddr_o = ioaddr_q;
  assign burst_o  = burst_q;
  assign armed_o  = armed_q;
  assign done_o   = done_q;

  // R6: every byte moves address up and count down by one
  p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |=> (count_q == $past(count_q) - CNT_W'(1)) &&
               (maddr_q == $past(maddr_q) + ADDR_W'(1)));

  // R11: last byte sets the status bit and disarms
  p_tc_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && count_q == CNT_W'(1)) |=> (done_q && !armed_q));

  // R2: an armed channel keeps its programming
  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && !step_i) |=> ($stable(count_q) && $stable(maddr_q) && $stable(ioaddr_q)));

  // R12: a clear with no competing set empties the bit
  p_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_tc && !set_zero) |=> !done_q);

endmodule

// File: rtl/dmac_prio.sv
`timescale 1ns/1ps
module dmac_prio #(
  parameter int NCH = 4,
  localparam int IW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic [NCH-1:0] req_i,
  output logic           any_o,
  output logic [IW-1:0]  idx_o
);

  always_comb begin
    idx_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IW'(i);
    end
  end

  assign any_o = |req_i;

  // R4: the chosen channel is requesting and no lower one is
  always_comb begin
    if (any_o) begin
      a_prio_r4: assert (req_i[idx_o] && ((req_i & ((NCH'(1) << idx_o) - NCH'(1))) == '0));
    end
  end

endmodule

// File: rtl/dmac_bus_fsm.sv
`timescale 1ns/1ps
module dmac_bus_fsm import dmac_pkg::*; #(
  parameter int NCH   = 4,
  parameter int CNT_W = 16,
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_any_i,
  input  logic [IW-1:0]    pend_idx_i,
  input  logic             hold_ack_i,
  input  logic             drq_sel_i,
  input  xmode_e           mode_sel_i,
  input  logic [CNT_W-1:0] count_sel_i,
  input  logic [CNT_W-1:0] burst_sel_i,
  output logic             hold_req_o,
  output logic [IW-1:0]    sel_o,
  output logic             stb_o
);

  bstate_e          state_q, state_n;
  logic [IW-1:0]    sel_q, sel_n;
  logic [CNT_W-1:0] bleft_q, bleft_n;
  logic             single_sel, last_byte, burst_end;

  assign single_sel = (mode_sel_i == XM_SINGLE) || (mode_sel_i == XM_RSVD);
  assign last_byte  = (count_sel_i == CNT_W'(1));
  assign burst_end  = (mode_sel_i == XM_BURST) && (bleft_q == CNT_W'(1));

  always_comb begin
    state_n = state_q;
    sel_n   = sel_q;
    bleft_n = bleft_q;
    stb_o   = 1'b0;
    case (state_q)
      BS_IDLE: begin
        if (pend_any_i && !hold_ack_i) begin
          state_n = BS_REQ;
          sel_n   = pend_idx_i;
        end
      end
      BS_REQ: begin
        if (hold_ack_i) begin
          state_n = BS_XFER;
          bleft_n = (burst_sel_i == '0) ? CNT_W'(1) : burst_sel_i;
        end
      end
      BS_XFER: begin
        if (drq_sel_i) begin
          stb_o   = 1'b1;
          bleft_n = bleft_q - CNT_W'(1);
          if (last_byte || single_sel || burst_end) state_n = BS_IDLE;
        end else begin
          state_n = BS_IDLE;
        end
      end
      default: state_n = BS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BS_IDLE;
      sel_q   <= '0;
      bleft_q <= '0;
    end else begin
      state_q <= state_n;
      sel_q   <= sel_n;
      bleft_q <= bleft_n;
    end
  end

  assign hold_req_o = (state_q != BS_IDLE);
  assign sel_o      = sel_q;

  // R7: a single-mode byte ends the ownership
  p_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stb_o && single_sel) |=> !hold_req_o);

  // R10: a withdrawn request in a transfer cycle releases the bus
  p_withdraw_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == BS_XFER && !drq_sel_i) |=> !hold_req_o);

endmodule

// File: rtl/dmac_quad.sv
`timescale 1ns/1ps
module dmac_quad import dmac_pkg::*; #(
  parameter int NCH    = 4,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 16,
  parameter int DW     = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [$clog2(NCH)-1:0] cfg_chan,
  input  logic [2:0]             cfg_sel,
  input  logic [DW-1:0]          cfg_wdata,
  input  logic [NCH-1:0]         drq_i,
  output logic [NCH-1:0]         dack_o,
  output logic                   hold_req_o,
  input  logic                   hold_ack_i,
  output logic                   xfer_stb_o,
  output logic                   xfer_to_mem_o,
  output logic [ADDR_W-1:0]      mem_addr_o,
  output logic [ADDR_W-1:0]      io_addr_o,
  output logic                   irq_o,
  output logic [NCH-1:0]         irq_status_o
);

  localparam int CHW = $clog2(NCH);

  xmode_e            ch_mode   [NCH];
  logic              ch_tomem  [NCH];
  logic [CNT_W-1:0]  ch_count  [NCH];
  logic [ADDR_W-1:0] ch_maddr  [NCH];
  logic [ADDR_W-1:0] ch_ioaddr [NCH];
  logic [CNT_W-1:0]  ch_burst  [NCH];
  logic [NCH-1:0]    ch_armed;
  logic [NCH-1:0]    ch_done;
  logic [NCH-1:0]    pend;
  logic              pend_any;
  logic [CHW-1:0]    pend_idx;
  logic [CHW-1:0]    sel;
  logic              stb;
  logic              clr_req;

  assign clr_req = cfg_we && (cfg_sel == RS_CLEAR);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dmac_chan_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DW(DW)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we && (cfg_chan == CHW'(g))),
      .wr_sel   (cfg_sel),
      .wr_data  (cfg_wdata),
      .clr_i    (clr_req && cfg_wdata[g]),
      .step_i   (stb && (sel == CHW'(g))),
      .mode_o   (ch_mode[g]),
      .to_mem_o (ch_tomem[g]),
      .count_o  (ch_count[g]),
      .maddr_o  (ch_maddr[g]),
      .ioaddr_o (ch_ioaddr[g]),
      .burst_o  (ch_burst[g]),
      .armed_o  (ch_armed[g]),
      .done_o   (ch_done[g])
    );
  end

  assign pend = ch_armed & drq_i;

  dmac_prio #(.NCH(NCH)) u_prio (
    .req_i (pend),
    .any_o (pend_any),
    .idx_o (pend_idx)
  );

  dmac_bus_fsm #(.NCH(NCH), .CNT_W(CNT_W)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .pend_any_i  (pend_any),
    .pend_idx_i  (pend_idx),
    .hold_ack_i  (hold_ack_i),
    .drq_sel_i   (drq_i[sel]),
    .mode_sel_i  (ch_mode[sel]),
    .count_sel_i (ch_count[sel]),
    .burst_sel_i (ch_burst[sel]),
    .hold_req_o  (hold_req_o),
    .sel_o       (sel),
    .stb_o       (stb)
  );

  always_comb begin
    dack_o = '0;
    if (stb) dack_o[sel] = 1'b1;
  end

  assign xfer_stb_o    = stb;
  assign xfer_to_mem_o = ch_tomem[sel];
  assign mem_addr_o    = ch_maddr[sel];
  assign io_addr_o     = ch_ioaddr[sel];
  assign irq_status_o  = ch_done;
  assign irq_o         = |ch_done;

  // R3: bytes move only on a granted bus
  p_grant_r3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_stb_o |-> (hold_req_o && hold_ack_i));

  // R5: exactly one acknowledge with each strobe, none otherwise
  p_dack_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(dack_o) == (xfer_stb_o ? 1 : 0));

  // R14: a new hold request follows a seen-low acknowledge
  p_regrant_r14: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_req_o) |-> $past(!hold_ack_i));

endmodule

// File: tb/dmac_quad_bench.sv
`timescale 1ns/1ps
module dmac_quad_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_chan = '0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  drq = '0;
  logic        hold_ack = 1'b0;
  logic [3:0]  dack;
  logic        hold_req, stb, to_mem, irq;
  logic [15:0] mem_addr, io_addr;
  logic [3:0]  irq_status;

  always #2.5 clk = ~clk;

  dmac_quad u_dmac_quad (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .drq_i(drq), .dack_o(dack),
    .hold_req_o(hold_req), .hold_ack_i(hold_ack), .xfer_stb_o(stb),
    .xfer_to_mem_o(to_mem), .mem_addr_o(mem_addr), .io_addr_o(io_addr),
    .irq_o(irq), .irq_status_o(irq_status)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model state
  int m_cnt[4], m_maddr[4], m_io[4], m_burst[4], m_mode[4];
  bit m_tomem[4], m_armed[4], m_done[4];
  int m_state = 0, m_sel = 0, m_bleft = 0;

  // processor model and observation
  int grant_delay = 0, release_lag = 0, gcnt = 0, rcnt = 0;
  bit prev_hold = 0, prev_ack = 0;
  int ep_cnt = 0;
  int ep_q[$], ch_q[$], a_q[$];

  task automatic chk(input int act, input int exp, input string req, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int m_status();
    int s = 0;
    for (int i = 0; i < 4; i++) if (m_done[i]) s |= (1 << i);
    return s;
  endfunction

  task automatic model_step();
    bit mstb;
    int ns, nsel, nbl, c;
    mstb = (m_state == 2) && drq[m_sel];
    ns = m_state; nsel = m_sel; nbl = m_bleft;
    case (m_state)
      0: begin
        if (!hold_ack) begin
          for (int i = 3; i >= 0; i--)
            if (m_armed[i] && drq[i]) begin ns = 1; nsel = i; end
        end
      end
      1: if (hold_ack) begin
        ns = 2;
        nbl = (m_burst[m_sel] == 0) ? 1 : m_burst[m_sel];
      end
      default: begin
        if (mstb) begin
          nbl = m_bleft - 1;
          if (m_cnt[m_sel] == 1 || m_mode[m_sel] == 0 || m_mode[m_sel] == 3 ||
              (m_mode[m_sel] == 1 && m_bleft == 1)) ns = 0;
        end else ns = 0;
      end
    endcase
    c = cfg_chan;
    if (cfg_we && cfg_sel == 3'd5) begin
      for (int i = 0; i < 4; i++) if (cfg_wdata[i]) m_done[i] = 0;
    end else if (cfg_we && !m_armed[c]) begin
      case (cfg_sel)
        3'd0: begin
          m_mode[c] = cfg_wdata[1:0];
          m_tomem[c] = cfg_wdata[2];
          if (cfg_wdata[3]) begin
            if (m_cnt[c] == 0) m_done[c] = 1;
            else m_armed[c] = 1;
          end
        end
        3'd1: m_cnt[c] = cfg_wdata;
        3'd2: m_maddr[c] = cfg_wdata;
        3'd3: m_io[c] = cfg_wdata;
        3'd4: m_burst[c] = cfg_wdata;
        default: ;
      endcase
    end
    if (mstb) begin
      if (m_cnt[m_sel] == 1) begin m_armed[m_sel] = 0; m_done[m_sel] = 1; end
      m_cnt[m_sel] = (m_cnt[m_sel] - 1) & 16'hFFFF;
      m_maddr[m_sel] = (m_maddr[m_sel] + 1) & 16'hFFFF;
    end
    m_state = ns; m_sel = nsel; m_bleft = nbl;
  endtask

  task automatic tick();
    bit e_stb;
    if (hold_req) begin
      if (gcnt >= grant_delay) begin hold_ack = 1; rcnt = release_lag; end
      else gcnt++;
    end else begin
      gcnt = 0;
      if (hold_ack && rcnt > 0) rcnt--;
      else hold_ack = 0;
    end
    #1;
    e_stb = (m_state == 2) && drq[m_sel];
    chk(hold_req, (m_state != 0), "R3", "hold_req");
    chk(stb, e_stb, "R5", "strobe");
    chk(dack, e_stb ? (1 << m_sel) : 0, "R5", "dack");
    chk(irq_status, m_status(), "R11", "status");
    chk(irq, (m_status() != 0), "R11", "irq");
    if (e_stb) begin
      chk(mem_addr, m_maddr[m_sel], "R6", "mem_addr");
      chk(io_addr, m_io[m_sel], "R5", "io_addr");
      chk(to_mem, m_tomem[m_sel], "R5", "to_mem");
    end
    if (hold_req && !prev_hold) chk(prev_ack, 0, "R14", "ack before new hold");
    if (stb) chk(hold_ack, 1, "R3", "strobe without grant");
    if (stb) begin
      ep_cnt++;
      for (int i = 0; i < 4; i++) if (dack[i]) ch_q.push_back(i);
      a_q.push_back(mem_addr);
    end
    if (prev_hold && !hold_req) begin ep_q.push_back(ep_cnt); ep_cnt = 0; end
    prev_hold = hold_req;
    prev_ack = hold_ack;
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic flush();
    ep_q.delete(); ch_q.delete(); a_q.delete();
  endtask

  // which: 0 episode lengths, 1 channel order, 2 strobe addresses
  task automatic chk_q(input int which, input int n, input int e[6], input string req);
    int q[$];
    if (which == 0) q = ep_q; else if (which == 1) q = ch_q; else q = a_q;
    chk(q.size(), n, req, "queue length");
    for (int i = 0; i < n && i < q.size(); i++) chk(q[i], e[i], req, "queue item");
  endtask

  task automatic wr(input int ch, input int sel, input int data);
    cfg_we = 1; cfg_chan = ch[1:0]; cfg_sel = sel[2:0]; cfg_wdata = data[15:0];
    tick();
    cfg_we = 0;
  endtask

  task automatic setup(input int ch, input int cnt, input int ma, input int io,
                       input int bl, input int mw);
    wr(ch, 1, cnt); wr(ch, 2, ma); wr(ch, 3, io); wr(ch, 4, bl); wr(ch, 0, mw);
  endtask

  initial begin
    #250000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin
      m_cnt[i] = 0; m_maddr[i] = 0; m_io[i] = 0; m_burst[i] = 0; m_mode[i] = 0;
      m_tomem[i] = 0; m_armed[i] = 0; m_done[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(hold_req, 0, "R1", "reset hold_req");
    chk(stb, 0, "R1", "reset strobe");
    chk(dack, 0, "R1", "reset dack");
    chk(irq, 0, "R1", "reset irq");
    chk(irq_status, 0, "R1", "reset status");
    @(negedge clk);
    drq = 4'hF; ticks(5);
    chk(ep_q.size() + hold_req, 0, "R1", "unarmed requests ignored");
    drq = 0; flush();

    // single mode, toward memory
    setup(1, 3, 16'h0200, 16'h0030, 0, 4 + 8);
    drq[1] = 1; ticks(40); drq = 0;
    chk_q(0, 3, '{1, 1, 1, 0, 0, 0}, "R7");
    chk_q(2, 3, '{16'h200, 16'h201, 16'h202, 0, 0, 0}, "R6");
    chk(irq_status, 4'b0010, "R11", "single done");
    wr(0, 5, 2);
    chk(irq_status, 0, "R12", "clear bit1");
    flush();

    // burst of 2 cut short at count 5
    setup(2, 5, 16'h0300, 16'h0040, 2, 1 + 8);
    drq[2] = 1; ticks(50); drq = 0;
    chk_q(0, 3, '{2, 2, 1, 0, 0, 0}, "R8");
    wr(0, 5, 4); flush();

    // burst length 0 acts as 1
    setup(3, 2, 16'h0310, 16'h0041, 0, 1 + 8);
    drq[3] = 1; ticks(30); drq = 0;
    chk_q(0, 2, '{1, 1, 0, 0, 0, 0}, "R8");
    wr(0, 5, 8); flush();

    // bulk
    setup(0, 4, 16'h0100, 16'h0010, 0, 2 + 8);
    drq[0] = 1; ticks(30); drq = 0;
    chk_q(0, 1, '{4, 0, 0, 0, 0, 0}, "R9");
    chk_q(2, 4, '{16'h100, 16'h101, 16'h102, 16'h103, 0, 0}, "R6");
    chk(irq, 1, "R11", "bulk irq");
    wr(0, 5, 1); flush();

    // priority on simultaneous requests
    setup(3, 2, 16'h0600, 16'h0063, 0, 2 + 8);
    setup(1, 2, 16'h0700, 16'h0071, 0, 2 + 8);
    drq = 4'b1010; ticks(40); drq = 0;
    chk_q(1, 4, '{1, 1, 3, 3, 0, 0}, "R4");
    wr(0, 5, 10); flush();

    // no pre-emption of an owning channel
    setup(3, 3, 16'h0800, 16'h0083, 0, 2 + 8);
    setup(0, 2, 16'h0900, 16'h0090, 0, 2 + 8);
    drq[3] = 1;
    while (ch_q.size() < 1) tick();
    drq[0] = 1; ticks(30); drq = 0;
    chk_q(1, 5, '{3, 3, 3, 0, 0, 0}, "R4");
    wr(0, 5, 9); flush();

    // request withdrawn mid-block
    setup(2, 4, 16'h0a00, 16'h00a2, 0, 2 + 8);
    drq[2] = 1;
    while (ch_q.size() < 2) tick();
    drq[2] = 0; ticks(10);
    chk_q(0, 1, '{2, 0, 0, 0, 0, 0}, "R10");
    flush();
    drq[2] = 1; ticks(30); drq = 0;
    chk_q(0, 1, '{2, 0, 0, 0, 0, 0}, "R10");
    chk(irq_status, 4'b0100, "R10", "resumed block done");
    wr(0, 5, 4); flush();

    // zero count arms straight to done
    drq[1] = 1;
    wr(1, 1, 0);
    wr(1, 0, 8);
    chk(irq_status, 4'b0010, "R13", "zero-count status");
    ticks(10); drq = 0;
    chk(ep_q.size(), 0, "R13", "no bus request");
    wr(0, 5, 2); flush();

    // armed registers are locked
    setup(0, 2, 16'h0400, 16'h0050, 0, 2 + 8);
    wr(0, 1, 9); wr(0, 2, 16'h0777);
    drq[0] = 1; ticks(20); drq = 0;
    chk_q(2, 2, '{16'h400, 16'h401, 0, 0, 0, 0}, "R2");
    wr(0, 5, 1); flush();

    // clear colliding with terminal count
    setup(1, 1, 16'h0550, 16'h0051, 0, 0 + 8);
    drq[1] = 1; ticks(20); drq = 0;
    chk(irq_status, 4'b0010, "R11", "single one byte");
    setup(0, 1, 16'h0500, 16'h0052, 0, 2 + 8);
    flush();
    drq[0] = 1;
    do tick(); while (hold_req !== 1'b1);
    tick();
    cfg_we = 1; cfg_chan = 0; cfg_sel = 3'd5; cfg_wdata = 16'h0003;
    tick();
    cfg_we = 0; drq = 0;
    chk(irq_status, 4'b0001, "R12", "set wins over clear");
    chk_q(1, 1, '{0, 0, 0, 0, 0, 0}, "R12");
    ticks(3);
    wr(0, 5, 1); flush();

    // slow grant and lagging acknowledge
    grant_delay = 3; release_lag = 2;
    setup(2, 2, 16'h0b00, 16'h00b2, 0, 0 + 8);
    drq[2] = 1; ticks(40); drq = 0;
    chk_q(0, 2, '{1, 1, 0, 0, 0, 0}, "R14");
    grant_delay = 0; release_lag = 0;
    ticks(4);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule